// File: doc/BRIEF.md
# Two-Level Page-Table Address Translator

This block turns a device-side virtual address into a physical address for one request at a time. Each request carries an address, a stream number and a read/write flag. A per-stream control register picks between three behaviours: pass-through, translation or refusal. When translation is on, the block reads a first-level (directory) entry through a base register and then a second-level (leaf) entry. It returns either the physical address or a fault cause.

Every leaf entry carries an allowed window inside its 16 KB page, with a lower and an upper limit at 4-byte granularity. An access outside that window faults, and the fault cause depends on the access direction. The page tables live in a small internal table memory. A byte-addressed write port loads that memory, and a 12-bit configuration write port loads the control and base registers.

The walk state machine has four states:
- `S_IDLE`: the block accepts a request.
- `S_DIR`: the directory entry is on the memory output.
- `S_LEAF`: the leaf entry is on the memory output.
- `S_RESP`: the response is presented for one cycle.

The transitions are:
- `S_IDLE -> S_DIR` on a translated request with a valid base.
- `S_IDLE -> S_RESP` on a request to a stream that is disabled or has no valid base.
- `S_DIR -> S_LEAF` on a valid directory entry.
- `S_DIR -> S_RESP` on an invalid directory entry.
- `S_LEAF -> S_RESP` always.
- `S_RESP -> S_IDLE` always.

A pass-through request never leaves `S_IDLE`.

Top module: `xlat_walk_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and every control and base register is clear. A request to any stream then answers with fault code 1.
- R2: When bit 8 of a stream's control register is set, a request answers in the same cycle with `rsp_valid`=1, `rsp_fault`=0, `rsp_code`=0 and `rsp_pa` equal to `req_addr`. This holds whether or not bit 7 is also set, and the request takes no busy cycle.
- R3: A stream whose control register has bit 7 and bit 8 both clear answers with fault code 1, even when its base registers are valid. A stream number of 4 or more (past `NUM_SID`) behaves the same way.
- R4: The control register of stream s is at config address 0x100+4*s. Base register i of stream s is at 0x200+16*s+4*i. In a base register, bit 31 is the valid flag and bits 25:0 hold the directory table's physical address shifted right by 12. Address bits 37:36 pick the base register.
- R5: A translated request whose selected base register has bit 31 clear answers with fault code 1.
- R6: The directory entry is read at table address + 8*va[35:25]. It is valid only when its bits 1:0 equal 3, and its bits 37:14 give the leaf table page. Any other value of bits 1:0 answers with fault code 2.
- R7: The leaf entry is read at leaf table + 8*va[24:14]. An entry with bit 0 clear answers with fault code 3.
- R8: The subpage va[13:2] must lie inside the inclusive window from the leaf entry's bits 63:52 (lower limit) to its bits 51:40 (upper limit). Outside the window, a write answers with fault code 4 and a read with fault code 5.
- R9: A successful walk answers with `rsp_fault`=0, `rsp_code`=0 and `rsp_pa` = {leaf[37:14], va[13:0]}. Any fault response carries `rsp_pa`=0 and `rsp_fault`=1.
- R10: The request is accepted on the clock edge where `req_valid` and `req_ready` are both 1. After that edge, `req_ready` stays low for a set number of cycles:
  - 1 cycle for a base fault;
  - 2 cycles for a directory fault;
  - 3 cycles for a leaf fault, a window fault or a success.
  `rsp_valid` is high during the last of those cycles.
- R11: The table memory folds a byte address pa onto the word {pa[16:14], pa[7:3]}. Writes through the memory port and reads by the walk both use this fold, so pages that are equal modulo 8 alias onto each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 12 | Configuration register byte address |
| cfg_wdata | input | 32 | Configuration write data |
| mem_we | input | 1 | Table memory write strobe |
| mem_addr | input | 38 | Table memory byte address (folded) |
| mem_wdata | input | 64 | Table entry to write |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 38 | Virtual address |
| req_sid | input | 4 | Stream number |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_ready | output | 1 | Walker idle and able to accept |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 3 | Fault cause (0 none, 1 base, 2 directory, 3 leaf, 4 write window, 5 read window) |
| rsp_pa | output | 38 | Translated physical address, 0 on a fault |

## Verification
The hardest situations to reach are the window edges and the fold aliasing. Both need a leaf entry that is valid, reached through a valid base and a valid directory entry, with the subpage placed exactly on, one step outside, or one step below the stored limits. The stimulus builds one complete table chain through the memory port. It then walks the same leaf with offsets on the inclusive lower and upper limits and one subpage beyond each, in both directions. A second leaf is written through an address on a page that folds onto the existing leaf table, and a walk through the existing directory entry reaches it.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int PG_SHIFT  = 14;
    localparam int ENT_SHIFT = 3;
    localparam int IDX_W     = PG_SHIFT - ENT_SHIFT;

    typedef enum logic [2:0] {
        F_NONE    = 3'd0,
        F_NO_BASE = 3'd1,
        F_NO_DIR  = 3'd2,
        F_NO_PAGE = 3'd3,
        F_WR_WIN  = 3'd4,
        F_RD_WIN  = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DIR,
        S_LEAF,
        S_RESP
    } walk_state_e;

endpackage

// File: rtl/xw_regs.sv
module xw_regs #(
    parameter int NUM_SID = 4,
    parameter int SID_W   = 4,
    parameter int SEL_W   = 2,
    parameter int PA_W    = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [SID_W-1:0]  look_sid,
    input  logic [SEL_W-1:0]  look_sel,
    output logic              look_en,
    output logic              look_byp,
    output logic              look_base_v,
    output logic [PA_W-1:0]   look_base_pa
);
    localparam int NBASE  = 1 << SEL_W;
    localparam int BASE_W = PA_W - 12;
    localparam int LSID_W = (NUM_SID > 1) ? $clog2(NUM_SID) : 1;

    logic [1:0]        ctrl_q [NUM_SID];
    logic [BASE_W:0]   base_q [NUM_SID][NBASE];

    for (genvar g = 0; g < NUM_SID; g++) begin : g_sid
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[g] <= '0;
            else if (cfg_we && cfg_addr[11:8] == 4'h1 && cfg_addr[7:2] == 6'(g))
                ctrl_q[g] <= {cfg_wdata[8], cfg_wdata[7]};
        end
        for (genvar h = 0; h < NBASE; h++) begin : g_base
            always_ff @(posedge clk) begin
                if (!rst_n)
                    base_q[g][h] <= '0;
                else if (cfg_we && cfg_addr[11:8] == 4'h2 &&
                         cfg_addr[7:4] == 4'(g) && cfg_addr[3:2] == 2'(h))
                    base_q[g][h] <= {cfg_wdata[31], cfg_wdata[BASE_W-1:0]};
            end
        end
    end

    logic              sid_ok;
    logic [LSID_W-1:0] sid_ix;
    logic [1:0]        ctrl_sel;
    logic [BASE_W:0]   base_sel;

    always_comb begin
        sid_ok   = (look_sid < SID_W'(NUM_SID));
        sid_ix   = sid_ok ? look_sid[LSID_W-1:0] : '0;
        ctrl_sel = sid_ok ? ctrl_q[sid_ix] : 2'b00;
        base_sel = sid_ok ? base_q[sid_ix][look_sel] : '0;
        look_en      = ctrl_sel[0];
        look_byp     = ctrl_sel[1];
        look_base_v  = base_sel[BASE_W];
        look_base_pa = {base_sel[BASE_W-1:0], 12'h000};
    end

endmodule

// File: rtl/xw_table_mem.sv
module xw_table_mem
    import xw_pkg::*;
#(
    parameter int PA_W    = 38,
    parameter int PG_BITS = 3,
    parameter int IX_BITS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_pa,
    input  logic [63:0]     wr_data,
    input  logic [PA_W-1:0] rd_pa,
    output logic [63:0]     rd_data
);
    localparam int AW    = PG_BITS + IX_BITS;
    localparam int DEPTH = 1 << AW;

    logic [63:0] cells [DEPTH];

    function automatic logic [AW-1:0] fold(input logic [PA_W-1:0] pa);
        return {pa[PG_SHIFT +: PG_BITS], pa[ENT_SHIFT +: IX_BITS]};
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[fold(wr_pa)] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= cells[fold(rd_pa)];
    end

endmodule

// File: rtl/xw_walk_fsm.sv
module xw_walk_fsm
    import xw_pkg::*;
#(
    parameter int VA_W = 38,
    parameter int PA_W = 38
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_addr,
    input  logic                   req_write,
    output logic                   req_ready,
    output logic [VA_W-PG_SHIFT-2*IDX_W-1:0] base_sel,
    input  logic                   lk_en,
    input  logic                   lk_byp,
    input  logic                   lk_base_v,
    input  logic [PA_W-1:0]        lk_base_pa,
    output logic [PA_W-1:0]        rd_pa,
    input  logic [63:0]            rd_data,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic [2:0]             rsp_code,
    output logic [PA_W-1:0]        rsp_pa
);
    localparam int DIR_LO = PG_SHIFT + IDX_W;
    localparam int SEL_LO = DIR_LO + IDX_W;

    walk_state_e     state, nstate;
    logic [VA_W-1:0] va_q;
    logic            wr_q;
    fault_e          code_q;
    logic [PA_W-1:0] pa_q;

    logic             accept, byp_hit, walk_go, base_ok, dir_ok, in_win;
    logic [IDX_W-1:0] dir_idx, leaf_idx;
    logic [PA_W-1:0]  leaf_tbl;
    logic [11:0]      sub, lim_lo, lim_hi;

    always_comb begin
        base_sel = req_addr[VA_W-1:SEL_LO];
        dir_idx  = req_addr[DIR_LO +: IDX_W];
        leaf_idx = va_q[PG_SHIFT +: IDX_W];
        accept   = (state == S_IDLE) && req_valid;
        byp_hit  = accept && lk_byp;
        walk_go  = accept && !lk_byp;
        base_ok  = lk_en && lk_base_v;
        dir_ok   = (rd_data[1:0] == 2'b11);
        leaf_tbl = {rd_data[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
        sub      = va_q[PG_SHIFT-1:2];
        lim_lo   = rd_data[63:52];
        lim_hi   = rd_data[51:40];
        in_win   = (sub >= lim_lo) && (sub <= lim_hi);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next state and table read address
    always_comb begin
        nstate = state;
        rd_pa  = '0;
        unique case (state)
            S_IDLE: begin
                rd_pa = lk_base_pa + (PA_W'(dir_idx) << ENT_SHIFT);
                if (walk_go) nstate = base_ok ? S_DIR : S_RESP;
            end
            S_DIR: begin
                rd_pa  = leaf_tbl + (PA_W'(leaf_idx) << ENT_SHIFT);
                nstate = dir_ok ? S_LEAF : S_RESP;
            end
            S_LEAF:  nstate = S_RESP;
            S_RESP:  nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            wr_q   <= 1'b0;
            code_q <= F_NONE;
            pa_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (walk_go) begin
                    va_q   <= req_addr;
                    wr_q   <= req_write;
                    pa_q   <= '0;
                    code_q <= base_ok ? F_NONE : F_NO_BASE;
                end
                S_DIR: if (!dir_ok) code_q <= F_NO_DIR;
                S_LEAF: begin
                    if (!rd_data[0])  code_q <= F_NO_PAGE;
                    else if (!in_win) code_q <= wr_q ? F_WR_WIN : F_RD_WIN;
                    else              pa_q   <= {rd_data[PA_W-1:PG_SHIFT], va_q[PG_SHIFT-1:0]};
                end
                S_RESP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == S_IDLE);
        rsp_valid = byp_hit || (state == S_RESP);
        rsp_fault = (state == S_RESP) && (code_q != F_NONE);
        rsp_code  = (state == S_RESP) ? code_q : F_NONE;
        if (byp_hit)               rsp_pa = PA_W'(req_addr);
        else if (state == S_RESP)  rsp_pa = pa_q;
        else                       rsp_pa = '0;
    end

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lk_byp) |=> !req_ready);

    assert_leaf_then_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LEAF) |=> (rsp_valid && !req_ready));

    assert_bypass_same_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_byp) |-> (rsp_valid && !rsp_fault && rsp_pa == PA_W'(req_addr)));

    assert_dir_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DIR && rd_data[1:0] != 2'b11) |=> (rsp_valid && rsp_code == 3'(F_NO_DIR)));

    assert_window_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LEAF && rd_data[0] && !in_win) |=>
        (rsp_fault && (rsp_code == 3'(F_WR_WIN) || rsp_code == 3'(F_RD_WIN))));

    assert_offset_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RESP && !rsp_fault) |-> (rsp_pa[PG_SHIFT-1:0] == va_q[PG_SHIFT-1:0]));

    assert_fault_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_code != 3'(F_NONE))));

endmodule

// File: rtl/xlat_walk_top.sv
module xlat_walk_top
    import xw_pkg::*;
#(
    parameter int NUM_SID = 4,
    parameter int SID_W   = 4,
    parameter int VA_W    = 38,
    parameter int PA_W    = 38,
    parameter int PG_BITS = 3,
    parameter int IX_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              mem_we,
    input  logic [PA_W-1:0]   mem_addr,
    input  logic [63:0]       mem_wdata,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_addr,
    input  logic [SID_W-1:0]  req_sid,
    input  logic              req_write,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_code,
    output logic [PA_W-1:0]   rsp_pa
);
    localparam int SEL_W = VA_W - PG_SHIFT - 2 * IDX_W;

    logic [SEL_W-1:0] base_sel;
    logic             lk_en, lk_byp, lk_base_v;
    logic [PA_W-1:0]  lk_base_pa, rd_pa;
    logic [63:0]      rd_data;

    xw_regs #(.NUM_SID(NUM_SID), .SID_W(SID_W), .SEL_W(SEL_W), .PA_W(PA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .look_sid(req_sid), .look_sel(base_sel),
        .look_en(lk_en), .look_byp(lk_byp),
        .look_base_v(lk_base_v), .look_base_pa(lk_base_pa)
    );

    xw_table_mem #(.PA_W(PA_W), .PG_BITS(PG_BITS), .IX_BITS(IX_BITS)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(mem_we), .wr_pa(mem_addr), .wr_data(mem_wdata),
        .rd_pa(rd_pa), .rd_data(rd_data)
    );

    xw_walk_fsm #(.VA_W(VA_W), .PA_W(PA_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_ready(req_ready), .base_sel(base_sel),
        .lk_en(lk_en), .lk_byp(lk_byp), .lk_base_v(lk_base_v), .lk_base_pa(lk_base_pa),
        .rd_pa(rd_pa), .rd_data(rd_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_pa(rsp_pa)
    );

endmodule

// File: tb/sim_xlat_walk_top.sv
module sim_xlat_walk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_we = 1'b0;
    logic [37:0] mem_addr = '0;
    logic [63:0] mem_wdata = '0;
    logic        req_valid = 1'b0;
    logic [37:0] req_addr = '0;
    logic [3:0]  req_sid = '0;
    logic        req_write = 1'b0;
    logic        req_ready, rsp_valid, rsp_fault;
    logic [2:0]  rsp_code;
    logic [37:0] rsp_pa;

    always #4 clk = ~clk;

    xlat_walk_top u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_sid(req_sid), .req_write(req_write),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .rsp_pa(rsp_pa)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [41:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: sample mid-cycle, after negedge-driven inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && rsp_valid) begin
                logic [41:0] act;
                act = {rsp_fault, rsp_code, rsp_pa};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected response", 64'(act), 64'h0);
                end else begin
                    logic [41:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(act == e, t, "response {fault,code,pa}", 64'(act), 64'(e));
                end
            end
        end
    end

    task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic mem_wr(input logic [37:0] a, input logic [63:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    function automatic logic [37:0] va(input int sel, input int dir, input int leaf, input int off);
        return (38'(sel) << 36) | (38'(dir) << 25) | (38'(leaf) << 14) | 38'(off);
    endfunction

    function automatic logic [63:0] leaf_ent(input logic [11:0] lo, input logic [11:0] hi,
                                             input logic [37:0] page);
        return (64'(lo) << 52) | (64'(hi) << 40) | 64'(page) | 64'h1;
    endfunction

    task automatic xlat(input logic [37:0] a, input int sid, input bit wr,
                        input bit e_fault, input int e_code, input logic [37:0] e_pa,
                        input int e_lat, input string tag);
        int lat;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back({e_fault, 3'(e_code), e_pa});
        tag_q.push_back(tag);
        req_valid = 1'b1; req_addr = a; req_sid = 4'(sid); req_write = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!req_ready && lat < 10) begin
            lat++;
            @(negedge clk);
        end
        chk(lat == e_lat, tag, "busy cycles after accept", 64'(lat), 64'(e_lat));
        @(negedge clk);
    endtask

    localparam logic [37:0] PG_A = 38'h3_ABCD_C000;
    localparam logic [37:0] PG_B = 38'h1_0000_4000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'h1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
        // R1: cleared registers -> base fault (code 1)
        xlat(va(0, 2, 5, 'h40), 0, 0, 1, 1, '0, 1, "R1");

        // R2: bypass alone, then bypass with enable
        cfg_wr(12'h104, 32'h0000_0100);
        xlat(38'h2_3456_789A, 1, 0, 0, 0, 38'h2_3456_789A, 0, "R2");
        cfg_wr(12'h104, 32'h0000_0180);
        xlat(38'h0_0000_1234, 1, 1, 0, 0, 38'h0_0000_1234, 0, "R2");

        // R5: enabled, base invalid
        cfg_wr(12'h100, 32'h0000_0080);
        xlat(va(0, 2, 5, 'h40), 0, 0, 1, 1, '0, 1, "R5");

        // R3: valid base but stream disabled; stream past NUM_SID
        cfg_wr(12'h220, 32'h8000_0004);
        xlat(va(0, 2, 5, 'h40), 2, 0, 1, 1, '0, 1, "R3");
        xlat(va(0, 2, 5, 'h40), 5, 0, 1, 1, '0, 1, "R3");

        // Build chain: base -> dir page 1 -> leaf page 2
        cfg_wr(12'h200, 32'h8000_0004);
        mem_wr(38'h4010, 64'h8003);
        mem_wr(38'h4020, 64'h8001);
        mem_wr(38'h8028, leaf_ent(12'h010, 12'h800, PG_A));

        // R9 and R8 lower limit inclusive
        xlat(va(0, 2, 5, 'h40), 0, 0, 0, 0, PG_A | 38'h40, 3, "R9");
        // R8 upper limit inclusive
        xlat(va(0, 2, 5, 'h2003), 0, 1, 0, 0, PG_A | 38'h2003, 3, "R8");
        // R8 above window: read -> 5, write -> 4
        xlat(va(0, 2, 5, 'h2004), 0, 0, 1, 5, '0, 3, "R8");
        xlat(va(0, 2, 5, 'h2004), 0, 1, 1, 4, '0, 3, "R8");
        // R8 below window
        xlat(va(0, 2, 5, 'h03C), 0, 1, 1, 4, '0, 3, "R8");
        xlat(va(0, 2, 5, 'h03C), 0, 0, 1, 5, '0, 3, "R8");

        // R6: empty dir entry, and entry with low bits 01
        xlat(va(0, 3, 5, 'h40), 0, 0, 1, 2, '0, 2, "R6");
        xlat(va(0, 4, 5, 'h40), 0, 0, 1, 2, '0, 2, "R6");

        // R7: empty leaf entry
        xlat(va(0, 2, 6, 'h40), 0, 0, 1, 3, '0, 3, "R7");

        // R4: select bits 37:36 pick base 1 (invalid, then valid)
        xlat(va(1, 2, 5, 'h100), 0, 0, 1, 1, '0, 1, "R4");
        cfg_wr(12'h204, 32'h8000_000C);
        mem_wr(38'hC010, 64'h8003);
        xlat(va(1, 2, 5, 'h100), 0, 0, 0, 0, PG_A | 38'h100, 3, "R4");

        // R11: leaf written through page 10, which folds onto page 2
        mem_wr(38'h2_8038, leaf_ent(12'h000, 12'hFFF, PG_B));
        xlat(va(0, 2, 7, 'h1234), 0, 0, 0, 0, PG_B | 38'h1234, 3, "R11");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10", "responses outstanding", 64'(exp_q.size()), 64'h0);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule